// File: doc/BRIEF.md
# Shifter-Fronted Data-Processing ALU

This block is the execute stage of a simple 32-bit integer datapath. One operation is issued per clock. The first operand is a register value. The second operand comes either from a register or from a small zero-extended immediate, and in both cases it first passes through a barrel shifter. The shifter applies one of four shift kinds by any amount from 0 to 31 in the same cycle. The sixteen operations fall into four groups: arithmetic (including reverse and carry-chained subtraction), bitwise logic (including bit-clear), moves, and flag-only comparisons.

The result and its write-enable are registered on the edge where an operation is presented. The block keeps the N, Z, C and V status flags itself. It updates them only when the operation asks for it. The held C flag feeds both the shifter (for a zero shift amount) and the carry-chained arithmetic.

Top module: `dpalu`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `result_we` is 0 and `flags` is 0. The flag order is N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R2: Logical opcodes give AND=0 (op1&op2), EOR=1 (op1^op2), ORR=12 (op1|op2) and BIC=14 (op1&~op2), where op2 is the shifted second operand.
- R3: MOV=13 returns the shifted op2 and MVN=15 returns its bitwise inverse. op1 has no effect on either.
- R4: ADD=4, SUB=2 (op1-op2) and RSB=3 (op2-op1) return the 32-bit result. When flags are set, C is the carry-out for ADD and NOT borrow for subtraction, and V is two's-complement overflow.
- R5: ADC=5 adds the current C. SBC=6 computes op1-op2-NOT C and RSC=7 computes op2-op1-NOT C. C and V follow the rules of R4.
- R6: TST=8 (AND), TEQ=9 (EOR), CMP=10 (SUB) and CMN=11 (ADD) never assert `result_we` and leave `result` unchanged. With set-flags they update the flags as their base operation would.
- R7: `shift_kind` selects LSL=0, LSR=1, ASR=2 or ROR=3 by `shift_amt` (0 to 31), and all of these complete within one cycle. `op2_sel_imm`=1 takes `imm` zero-extended in place of `op2_reg`. For example, LSL by 2 multiplies by 4.
- R8: A shift amount of 0 passes the operand unchanged, and the shifter carry then equals the current C flag.
- R9: For logical, move and test operations with set-flags, C becomes the last bit shifted out and V keeps its value.
- R10: With set-flags, N is result bit 31 and Z is 1 exactly when the result is zero.
- R11: Outputs change on the rising edge where `op_valid` is high. `result_we` is 0 after an edge without `op_valid`, and `result` holds. The flags change only on an edge with both `op_valid` and `set_flags` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code (see R2 to R6) |
| set_flags | input | 1 | Update N, Z, C, V from this operation |
| op1 | input | 32 | First operand |
| op2_reg | input | 32 | Register second operand |
| op2_sel_imm | input | 1 | Use `imm` instead of `op2_reg` |
| imm | input | 8 | Immediate, zero-extended |
| shift_kind | input | 2 | Shift type applied to op2 |
| shift_amt | input | 5 | Shift amount 0 to 31 |
| result | output | 32 | Registered operation result |
| result_we | output | 1 | Result write-enable |
| flags | output | 4 | N, Z, C, V status flags |

## Verification
The bench targets the shifter edges: amount 0, amount 1 and amount 31 for each shift kind. At those amounts a design that takes the carry from the wrong bit, or that treats a zero amount as a full-width shift, returns a wrong C or a wrong operand. For subtraction it covers equal operands, the most-negative boundary and borrow-in with C clear, because an inverted borrow sense or a swapped reverse operand order shows up there as wrong C or V. It also checks that comparisons never raise the write-enable or disturb the held result, and that logical operations leave V untouched. A design that cleared V or wrote back compare results would fail those checks.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_ROR = 2'd3
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // flag-only operations occupy codes 8..11
  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
  endfunction

  // operands reversed for the reverse subtractions
  function automatic logic op_is_reverse(input logic [3:0] op);
    return op == 4'd3 || op == 4'd7;
  endfunction

  function automatic logic op_is_subtract(input logic [3:0] op);
    return op == 4'd2 || op == 4'd3 || op == 4'd6 || op == 4'd7 || op == 4'd10;
  endfunction

  function automatic logic op_uses_carry(input logic [3:0] op);
    return op == 4'd5 || op == 4'd6 || op == 4'd7;
  endfunction

  // signed overflow of a + b, given the sum
  function automatic logic add_overflow(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

endpackage

// File: rtl/dpalu_shifter.sv
module dpalu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    val,
  input  logic [1:0]      kind,
  input  logic [SH_W-1:0] amt,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout
);
  import dpalu_pkg::*;

  logic [W-1:0] stage [SH_W+1];
  assign stage[0] = val;

  // log-depth barrel: stage k shifts by 2**k when amt[k] is set
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      unique case (shift_e'(kind))
        SH_LSL:  moved = stage[k] << D;
        SH_LSR:  moved = stage[k] >> D;
        SH_ASR:  moved = W'($signed(stage[k]) >>> D);
        default: moved = (stage[k] >> D) | (stage[k] << (W - D));
      endcase
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign res = stage[SH_W];

  // index of the last bit shifted out
  logic [SH_W-1:0] lo_idx, hi_idx;
  assign lo_idx = amt - SH_W'(1);
  assign hi_idx = ~amt + SH_W'(1);

  always_comb begin
    if (amt == '0)                       cout = cin;
    else if (shift_e'(kind) == SH_LSL)   cout = val[hi_idx];
    else                                 cout = val[lo_idx];
  end
endmodule

// File: rtl/dpalu_addsub.sv
module dpalu_addsub #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_flag,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  import dpalu_pkg::*;

  logic [W-1:0] x, y, y_eff;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    x = op_is_reverse(op) ? b : a;
    y = op_is_reverse(op) ? a : b;
    y_eff = op_is_subtract(op) ? ~y : y;
    if (op_uses_carry(op))      cin = c_flag;
    else                        cin = op_is_subtract(op);
  end

  assign wide = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = add_overflow(x[W-1], y_eff[W-1], wide[W-1]);
endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  import dpalu_pkg::*;

  always_comb begin
    unique case (alu_op_e'(op))
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_BIC:         res = a & ~b;
      OP_MOV:         res = b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/dpalu.sv
module dpalu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2_reg,
  input  logic              op2_sel_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        shift_kind,
  input  logic [SH_W-1:0]   shift_amt,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [3:0]        flags
);
  import dpalu_pkg::*;

  flags_t flags_q, flags_nx;
  logic [DATA_W-1:0] op2_src, op2_sh, arith_res, logic_res, alu_res;
  logic sh_carry, add_c, add_v, is_arith, writes, flag_upd;

  assign op2_src = op2_sel_imm ? DATA_W'(imm) : op2_reg;

  dpalu_shifter #(.W(DATA_W), .SH_W(SH_W)) u_shift (
    .val(op2_src), .kind(shift_kind), .amt(shift_amt),
    .cin(flags_q.c), .res(op2_sh), .cout(sh_carry)
  );

  dpalu_addsub #(.W(DATA_W)) u_add (
    .op(opcode), .a(op1), .b(op2_sh), .c_flag(flags_q.c),
    .sum(arith_res), .cout(add_c), .ovf(add_v)
  );

  dpalu_logic #(.W(DATA_W)) u_logic (
    .op(opcode), .a(op1), .b(op2_sh), .res(logic_res)
  );

  assign is_arith = op_is_arith(opcode);
  assign writes   = !op_is_compare(opcode);
  assign alu_res  = is_arith ? arith_res : logic_res;
  assign flag_upd = op_valid && set_flags;

  always_comb begin
    flags_nx.n = alu_res[DATA_W-1];
    flags_nx.z = (alu_res == '0);
    flags_nx.c = is_arith ? add_c : sh_carry;
    flags_nx.v = is_arith ? add_v : flags_q.v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_q   <= '0;
    end else begin
      result_we <= op_valid && writes;
      if (op_valid && writes) result <= alu_res;
      if (flag_upd)           flags_q <= flags_nx;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/dpalu_checker.sv
module dpalu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  opcode,
  input logic        set_flags,
  input logic [4:0]  shift_amt,
  input logic [31:0] result,
  input logic        result_we,
  input logic [3:0]  flags,
  input logic        sh_carry
);
  AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode[3:2] == 2'b10 |=> !result_we && $stable(result)); // R6

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !result_we && $stable(result)); // R11

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && set_flags) |=> $stable(flags)); // R11

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && set_flags && opcode[3:2] != 2'b10 |=> flags[2] == (result == 32'd0)); // R10

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && set_flags && opcode[3:2] != 2'b10 |=> flags[3] == result[31]); // R10

  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && set_flags && (opcode inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15})
    |=> flags[0] == $past(flags[0])); // R9

  AST_ZERO_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_amt == 5'd0 |-> sh_carry == flags[1]); // R8
endmodule

bind dpalu dpalu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .set_flags(set_flags), .shift_amt(shift_amt), .result(result),
  .result_we(result_we), .flags(flags), .sh_carry(sh_carry)
);

// File: tb/tb_dpalu.sv
module tb_dpalu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic        set_flags = 1'b0;
  logic [31:0] op1 = '0, op2_reg = '0;
  logic        op2_sel_imm = 1'b0;
  logic [7:0]  imm = '0;
  logic [1:0]  shift_kind = '0;
  logic [4:0]  shift_amt = '0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  flags;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  bit [31:0] m_res = 0;
  bit        m_we = 0;
  bit [3:0]  m_flags = 0;

  always #10 clk = ~clk;

  dpalu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .set_flags(set_flags), .op1(op1), .op2_reg(op2_reg),
    .op2_sel_imm(op2_sel_imm), .imm(imm), .shift_kind(shift_kind),
    .shift_amt(shift_amt), .result(result), .result_we(result_we), .flags(flags)
  );

  function automatic void model_shift(input bit [31:0] x, input int k, input int n,
                                      input bit cin, output bit [31:0] r, output bit co);
    longint unsigned w = x;
    int sx = x;
    if (n == 0) begin r = x; co = cin; return; end
    case (k)
      0: begin r = x << n; co = ((w << n) >> 32) & 1; end
      1: begin r = x >> n; co = (w >> (n - 1)) & 1; end
      2: begin r = sx >>> n; co = (w >> (n - 1)) & 1; end
      default: begin r = (x >> n) | (x << (32 - n)); co = r[31]; end
    endcase
  endfunction

  // x + y + ci  or  x - y - bi, computed in wide integers
  function automatic void model_arith(input bit [31:0] x, input bit [31:0] y, input bit sub,
                                      input int extra, output bit [31:0] r, output bit c, output bit v);
    longint ux = x, uy = y;
    longint sx = $signed(x), sy = $signed(y);
    longint us, ss;
    if (sub) begin us = ux - uy - extra; ss = sx - sy - extra; c = (us >= 0); end
    else     begin us = ux + uy + extra; ss = sx + sy + extra; c = (us >= 64'h1_0000_0000); end
    r = us[31:0];
    v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
  endfunction

  task automatic step(input bit v, input int op, input bit sf, input bit [31:0] a,
                      input bit [31:0] b, input bit isimm, input bit [7:0] im,
                      input int sk, input int sa, input string tag);
    bit [31:0] o2, sh, r;
    bit sc, c, vv, arith, cmp;
    op_valid = v; opcode = op[3:0]; set_flags = sf; op1 = a; op2_reg = b;
    op2_sel_imm = isimm; imm = im; shift_kind = sk[1:0]; shift_amt = sa[4:0];
    o2 = isimm ? {24'd0, im} : b;
    model_shift(o2, sk, sa, m_flags[1], sh, sc);
    c = sc; vv = m_flags[0]; arith = 1;
    case (op)
      0, 8:  begin r = a & sh; arith = 0; end
      1, 9:  begin r = a ^ sh; arith = 0; end
      12:    begin r = a | sh; arith = 0; end
      13:    begin r = sh;     arith = 0; end
      14:    begin r = a & ~sh; arith = 0; end
      15:    begin r = ~sh;    arith = 0; end
      2, 10: model_arith(a, sh, 1, 0, r, c, vv);
      3:     model_arith(sh, a, 1, 0, r, c, vv);
      4, 11: model_arith(a, sh, 0, 0, r, c, vv);
      5:     model_arith(a, sh, 0, m_flags[1], r, c, vv);
      6:     model_arith(a, sh, 1, !m_flags[1], r, c, vv);
      default: model_arith(sh, a, 1, !m_flags[1], r, c, vv);
    endcase
    if (arith == 0) vv = m_flags[0];
    cmp = (op >= 8 && op <= 11);
    m_we = v && !cmp;
    if (v && !cmp) m_res = r;
    if (v && sf) m_flags = {r[31], r == 0, c, vv};
    @(negedge clk);
    checks++;
    if (result !== m_res || result_we !== m_we || flags !== m_flags) begin
      errors++;
      $display("FAIL %s op=%0d: got res=%h we=%b flags=%b, expected res=%h we=%b flags=%b",
               tag, op, result, result_we, flags, m_res, m_we, m_flags);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 0 || result_we !== 0 || flags !== 0) begin
      errors++;
      $display("FAIL R1 reset: got res=%h we=%b flags=%b, expected 0 0 0000", result, result_we, flags);
    end
    rst_n = 1'b1;
    // R7: LSL by 2 multiplies by 4
    step(1, 4, 1, 32'd10, 32'd3, 0, 0, 0, 2, "R7");
    // R2 logic group
    step(1, 0, 1, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 32'hAAAA_0000, 32'h5555_FFFF, 0, 0, 1, 4, "R2");
    step(1, 12, 1, 32'h0000_0001, 32'h8000_0000, 0, 0, 3, 31, "R2");
    step(1, 14, 1, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, 0, 8, "R2");
    // R3 moves, immediate path
    step(1, 13, 1, 32'hDEAD_BEEF, 0, 1, 8'hA5, 3, 4, "R3");
    step(1, 15, 1, 32'h1234_5678, 0, 1, 8'h00, 0, 0, "R3");
    // R4 arithmetic corners
    step(1, 4, 1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, "R4");
    step(1, 2, 1, 32'h8000_0000, 32'd1, 0, 0, 0, 0, "R4");
    step(1, 2, 1, 32'd5, 32'd5, 0, 0, 0, 0, "R4");
    step(1, 3, 1, 32'd7, 32'd3, 0, 0, 0, 0, "R4");
    step(1, 4, 1, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, "R4");
    // R5 carry chained, C clear then set
    step(1, 2, 1, 32'd1, 32'd2, 0, 0, 0, 0, "R5");
    step(1, 6, 1, 32'd10, 32'd3, 0, 0, 0, 0, "R5");
    step(1, 7, 1, 32'd10, 32'd3, 0, 0, 0, 0, "R5");
    step(1, 5, 1, 32'hFFFF_FFFF, 32'd0, 0, 0, 0, 0, "R5");
    step(1, 5, 1, 32'd1, 32'd1, 0, 0, 0, 0, "R5");
    // R6 compares never write
    step(1, 10, 1, 32'd9, 32'd9, 0, 0, 0, 0, "R6");
    step(1, 11, 1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, "R6");
    step(1, 8, 1, 32'hF0, 32'h0F, 0, 0, 0, 0, "R6");
    step(1, 9, 0, 32'h1, 32'h1, 0, 0, 0, 0, "R6");
    // R8 zero amount keeps C, R9 logic takes shifter carry
    step(1, 4, 1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, "R8");
    step(1, 13, 1, 0, 32'h8000_0001, 0, 0, 1, 0, "R8");
    step(1, 2, 1, 32'h8000_0000, 32'd1, 0, 0, 0, 0, "R9");
    step(1, 13, 1, 0, 32'h8000_0001, 0, 0, 0, 1, "R9");
    step(1, 13, 1, 0, 32'h0000_0002, 0, 0, 1, 2, "R9");
    for (int k = 0; k < 4; k++) begin
      step(1, 13, 1, 0, 32'h8000_0001, 0, 0, k, 1, "R7");
      step(1, 13, 1, 0, 32'h8000_0001, 0, 0, k, 31, "R7");
    end
    // R10 / R11 hold behaviour
    step(1, 4, 0, 32'd1, 32'd2, 0, 0, 0, 0, "R10");
    step(0, 4, 1, 32'd0, 32'd0, 0, 0, 0, 0, "R11");
    step(0, 2, 1, 32'd7, 32'd3, 0, 0, 0, 0, "R11");
    // randomized sweep across all operations
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15), $urandom_range(0, 1),
           $urandom, $urandom, $urandom_range(0, 1), 8'($urandom),
           $urandom_range(0, 3), $urandom_range(0, 31), "R10");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule